// File: doc/BRIEF.md
# Binary Calendar Clock with Field Alarms

This block keeps the time of day and the calendar for a real-time clock and holds every value in plain binary. A one-second tick from an external prescaler moves the counters forward. Each tick can cascade a carry through seconds, minutes, hours, weekday, day of month, month, year and century in the same cycle. Hours run either as 0 to 23 or as 1 to 12, with a PM flag in the top bit of the hours byte.

Four alarm bytes cover seconds, minutes, hours and day of month. Each one is compared with the freshly advanced time. When all four agree, an alarm flag is raised. An update flag marks every advance. A flag byte collects both flags together with a combined interrupt bit, which also drives the interrupt pin. Software reaches every byte through a small synchronous read/write port. A read returns its data on the cycle after the request.

Top module: `rtc_bincal`

## Requirements
- R1: After reset the time reads 00:00:00 in hours, minutes and seconds, with weekday 1, day of month 1, month 1, year 0 and century 0. The control byte reads 0x06, all four alarm bytes read 0, the flag byte reads 0 and irq is low.
- R2: Seconds and minutes count 0 to 59 and return to 0 at 59. Each wrap carries one into the next field.
- R3: When control bit 1 is 1 (24-hour mode), hours count 0 to 23, and 23 returns to 0 with a carry into the day.
- R4: When control bit 1 is 0 (12-hour mode), hours bits 6:0 hold 1 to 12 and bit 7 is 1 for PM. Going from 11 to 12 inverts bit 7. Going from 12 to 1 keeps bit 7. Only 11 PM to 12 AM carries into the day.
- R5: On a day carry, the weekday wraps from 7 to 1. The day of month wraps to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, 31 days for the other months, and 29 days for month 2 when year mod 4 is 0, otherwise 28.
- R6: Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0 and carries into the century. Century 99 wraps to 0.
- R7: While control bit 7 (halt) is 1, ticks change no time field and set no flag.
- R8: Each tick that advances the time sets the update flag, which is bit 4 of the flag byte.
- R9: An advance sets the alarm flag (flag byte bit 5) when the seconds, minutes, hours and day-of-month alarm bytes each equal the new value of their field. An alarm byte whose bits 7:6 are 11 matches any value.
- R10: Flag bit 7 and the irq pin equal (alarm flag AND control bit 5) OR (update flag AND control bit 4). Flag bits 6 and 3:0 read 0.
- R11: Reading the flag byte returns its value and then clears the byte. A flag set by an advance in the same cycle as that read survives the clear.
- R12: A write to seconds keeps only bits 5:0, so bits 7:6 read 0. Every other time byte and alarm byte stores all 8 written bits.
- R13: Addresses are as follows. Time fields: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, day of month 0x07, month 0x08, year 0x09, century 0x48. Alarm bytes: seconds 0x01, minutes 0x03, hours 0x05, day of month 0x49. Control is at 0x0B and flags at 0x0C; other addresses read 0. Read data appears one cycle after rd_en. A write in a tick cycle replaces the advanced value of the field it targets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 7 | Byte address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt, active high |

## Verification
The hardest situations to reach are the long carries: the year-end chain that ripples into the century, and the month ends that depend on the leap rule. With the port alone, reaching them would take millions of ticks. The stimulus therefore writes a time one second before each boundary and then issues a single tick. The read/clear race on the flag byte needs the read strobe and the tick in the very same cycle, so a directed step drives both on one edge. It then reads the flags twice.

// File: rtl/rtc_bincal_pkg.sv
package rtc_bincal_pkg;
  localparam int DW    = 8;
  localparam int AW    = 7;
  localparam int N_ALM = 4;

  typedef logic [DW-1:0] byte_t;

  // time fields, most significant first
  typedef struct packed {
    byte_t cent, year, mon, date, dow, hour, min, sec;
  } caltime_t;

  localparam logic [AW-1:0] A_SEC      = 7'h00;
  localparam logic [AW-1:0] A_SEC_ALM  = 7'h01;
  localparam logic [AW-1:0] A_MIN      = 7'h02;
  localparam logic [AW-1:0] A_MIN_ALM  = 7'h03;
  localparam logic [AW-1:0] A_HOUR     = 7'h04;
  localparam logic [AW-1:0] A_HOUR_ALM = 7'h05;
  localparam logic [AW-1:0] A_DOW      = 7'h06;
  localparam logic [AW-1:0] A_DATE     = 7'h07;
  localparam logic [AW-1:0] A_MON      = 7'h08;
  localparam logic [AW-1:0] A_YEAR     = 7'h09;
  localparam logic [AW-1:0] A_CTRL     = 7'h0B;
  localparam logic [AW-1:0] A_FLAG     = 7'h0C;
  localparam logic [AW-1:0] A_CENT     = 7'h48;
  localparam logic [AW-1:0] A_DATE_ALM = 7'h49;

  // control byte bit positions
  localparam int CB_HALT = 7;
  localparam int CB_AIE  = 5;
  localparam int CB_UIE  = 4;
  localparam int CB_H24  = 1;
  localparam byte_t CTRL_RST = 8'h06;

  // alarm lane order
  localparam int L_SEC  = 0;
  localparam int L_MIN  = 1;
  localparam int L_HOUR = 2;
  localparam int L_DATE = 3;

  function automatic byte_t month_days(input byte_t mon, input byte_t year);
    case (mon)
      8'd4, 8'd6, 8'd9, 8'd11: month_days = 8'd30;
      8'd2:                    month_days = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      default:                 month_days = 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bincal_chain.sv
module rtc_bincal_chain
  import rtc_bincal_pkg::*;
(
  input  caltime_t cur_i,
  input  logic     h24_i,
  output caltime_t nxt_o
);
  logic  c_min, c_hr, c_day, c_mon, c_yr, c_cent;
  logic  pm;
  logic [6:0] h12;
  byte_t mdays;

  always_comb begin
    nxt_o  = cur_i;
    c_min  = 1'b0;
    c_hr   = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_yr   = 1'b0;
    c_cent = 1'b0;
    pm     = cur_i.hour[7];
    h12    = cur_i.hour[6:0];
    mdays  = month_days(cur_i.mon, cur_i.year);

    if (cur_i.sec[5:0] >= 6'd59) begin
      nxt_o.sec = '0;
      c_min     = 1'b1;
    end else begin
      nxt_o.sec = {2'b00, cur_i.sec[5:0] + 6'd1};
    end

    if (c_min) begin
      if (cur_i.min >= 8'd59) begin
        nxt_o.min = '0;
        c_hr      = 1'b1;
      end else begin
        nxt_o.min = cur_i.min + 8'd1;
      end
    end

    if (c_hr) begin
      if (h24_i) begin
        if (cur_i.hour >= 8'd23) begin
          nxt_o.hour = '0;
          c_day      = 1'b1;
        end else begin
          nxt_o.hour = cur_i.hour + 8'd1;
        end
      end else begin
        if (h12 == 7'd11) begin
          nxt_o.hour = {~pm, 7'd12};
          c_day      = pm;
        end else if (h12 >= 7'd12) begin
          nxt_o.hour = {pm, 7'd1};
        end else begin
          nxt_o.hour = {pm, h12 + 7'd1};
        end
      end
    end

    if (c_day) begin
      nxt_o.dow = (cur_i.dow >= 8'd7) ? 8'd1 : cur_i.dow + 8'd1;
      if (cur_i.date >= mdays) begin
        nxt_o.date = 8'd1;
        c_mon      = 1'b1;
      end else begin
        nxt_o.date = cur_i.date + 8'd1;
      end
    end

    if (c_mon) begin
      if (cur_i.mon >= 8'd12) begin
        nxt_o.mon = 8'd1;
        c_yr      = 1'b1;
      end else begin
        nxt_o.mon = cur_i.mon + 8'd1;
      end
    end

    if (c_yr) begin
      if (cur_i.year >= 8'd99) begin
        nxt_o.year = '0;
        c_cent     = 1'b1;
      end else begin
        nxt_o.year = cur_i.year + 8'd1;
      end
    end

    if (c_cent) begin
      nxt_o.cent = (cur_i.cent >= 8'd99) ? 8'd0 : cur_i.cent + 8'd1;
    end
  end

  // R3: an in-range 24-hour value stays in range
  always_comb begin
    if (h24_i && cur_i.hour < 8'd24)
      a_r3_hour_bound: assert (nxt_o.hour < 8'd24);
  end

  // R5: a non-zero day of month never advances to zero
  always_comb begin
    if (cur_i.date != 8'd0)
      a_r5_date_nonzero: assert (nxt_o.date != 8'd0);
  end
endmodule

// File: rtl/rtc_bincal_alarm.sv
module rtc_bincal_alarm
  import rtc_bincal_pkg::*;
#(
  parameter int N   = N_ALM,
  parameter int W   = DW
) (
  input  logic [N-1:0][W-1:0] val_i,
  input  logic [N-1:0][W-1:0] alm_i,
  output logic                hit_o
);
  logic [N-1:0] lane_hit;

  for (genvar g = 0; g < N; g++) begin : g_lane
    // top two bits both set turn the lane into a wildcard
    assign lane_hit[g] = (alm_i[g][W-1:W-2] == 2'b11) || (alm_i[g] == val_i[g]);
  end

  assign hit_o = &lane_hit;
endmodule

// File: rtl/rtc_bincal.sv
module rtc_bincal
  import rtc_bincal_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ln = rst_pipe[SYNC_STAGES-1];

  caltime_t                   time_q, time_d, adv;
  logic [N_ALM-1:0][DW-1:0]   alm_q, alm_d, alm_val;
  byte_t                      ctrl_q, ctrl_d;
  logic                       af_q, af_d, uf_q, uf_d;
  byte_t                      rd_q, rd_d;
  logic                       step, hit, rd_flags;

  assign step     = tick_i && !ctrl_q[CB_HALT];
  assign rd_flags = rd_en_i && (addr_i == A_FLAG);

  rtc_bincal_chain u_chain (
    .cur_i (time_q),
    .h24_i (ctrl_q[CB_H24]),
    .nxt_o (adv)
  );

  assign alm_val = {adv.date, adv.hour, adv.min, adv.sec};

  rtc_bincal_alarm #(.N(N_ALM), .W(DW)) u_alarm (
    .val_i (alm_val),
    .alm_i (alm_q),
    .hit_o (hit)
  );

  // next state
  always_comb begin
    time_d = step ? adv : time_q;
    alm_d  = alm_q;
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      case (addr_i)
        A_SEC:      time_d.sec  = {2'b00, wr_data_i[5:0]};
        A_MIN:      time_d.min  = wr_data_i;
        A_HOUR:     time_d.hour = wr_data_i;
        A_DOW:      time_d.dow  = wr_data_i;
        A_DATE:     time_d.date = wr_data_i;
        A_MON:      time_d.mon  = wr_data_i;
        A_YEAR:     time_d.year = wr_data_i;
        A_CENT:     time_d.cent = wr_data_i;
        A_SEC_ALM:  alm_d[L_SEC]  = wr_data_i;
        A_MIN_ALM:  alm_d[L_MIN]  = wr_data_i;
        A_HOUR_ALM: alm_d[L_HOUR] = wr_data_i;
        A_DATE_ALM: alm_d[L_DATE] = wr_data_i;
        A_CTRL:     ctrl_d = wr_data_i;
        default: ;
      endcase
    end
  end

  // flags: clear on read, a fresh set wins
  always_comb begin
    af_d = (af_q && !rd_flags) || (step && hit);
    uf_d = (uf_q && !rd_flags) || step;
  end

  assign irq_o = (af_q && ctrl_q[CB_AIE]) || (uf_q && ctrl_q[CB_UIE]);

  always_comb begin
    rd_d = rd_q;
    if (rd_en_i) begin
      case (addr_i)
        A_SEC:      rd_d = time_q.sec;
        A_MIN:      rd_d = time_q.min;
        A_HOUR:     rd_d = time_q.hour;
        A_DOW:      rd_d = time_q.dow;
        A_DATE:     rd_d = time_q.date;
        A_MON:      rd_d = time_q.mon;
        A_YEAR:     rd_d = time_q.year;
        A_CENT:     rd_d = time_q.cent;
        A_SEC_ALM:  rd_d = alm_q[L_SEC];
        A_MIN_ALM:  rd_d = alm_q[L_MIN];
        A_HOUR_ALM: rd_d = alm_q[L_HOUR];
        A_DATE_ALM: rd_d = alm_q[L_DATE];
        A_CTRL:     rd_d = ctrl_q;
        A_FLAG:     rd_d = {irq_o, 1'b0, af_q, uf_q, 4'b0000};
        default:    rd_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      time_q <= '{cent: 8'd0, year: 8'd0, mon: 8'd1, date: 8'd1,
                  dow: 8'd1, hour: 8'd0, min: 8'd0, sec: 8'd0};
      alm_q  <= '0;
      ctrl_q <= CTRL_RST;
      af_q   <= 1'b0;
      uf_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      time_q <= time_d;
      alm_q  <= alm_d;
      ctrl_q <= ctrl_d;
      af_q   <= af_d;
      uf_q   <= uf_d;
      rd_q   <= rd_d;
    end
  end

  assign rd_data_o = rd_q;

  // R2: seconds at 59 wrap to 0 and push the minutes on
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_ln)
    (step && !wr_en_i && time_q.sec == 8'd59)
      |=> (time_q.sec == 8'd0 && time_q.min != $past(time_q.min)));

  // R7: halt freezes the time
  a_r7_halt_freeze: assert property (@(posedge clk) disable iff (!rst_ln)
    (ctrl_q[CB_HALT] && !wr_en_i) |=> $stable(time_q));

  // R9: a full alarm match on an advance raises the alarm flag
  a_r9_alarm_sets: assert property (@(posedge clk) disable iff (!rst_ln)
    (step && hit) |=> af_q);

  // R11: a flag read with no advance leaves the interrupt low
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_ln)
    (rd_flags && !step) |=> !irq_o);
endmodule

// File: tb/tb_rtc_bincal.sv
module tb_rtc_bincal;
  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic       rd_en;
  logic [6:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  rtc_bincal dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {24h mode, start time, expected time}; time = {cent,year,mon,date,dow,hour,min,sec}
  localparam int NV = 12;
  localparam logic [128:0] VEC [NV] = '{
    {1'b1, 64'h00_00_01_01_01_00_00_05, 64'h00_00_01_01_01_00_00_06},
    {1'b1, 64'h00_00_01_01_01_00_0A_3B, 64'h00_00_01_01_01_00_0B_00},
    {1'b1, 64'h14_63_0C_1F_07_17_3B_3B, 64'h15_00_01_01_01_00_00_00},
    {1'b1, 64'h14_18_02_1C_02_17_3B_3B, 64'h14_18_02_1D_03_00_00_00},
    {1'b1, 64'h14_17_02_1C_02_17_3B_3B, 64'h14_17_03_01_03_00_00_00},
    {1'b1, 64'h14_18_02_1D_04_17_3B_3B, 64'h14_18_03_01_05_00_00_00},
    {1'b1, 64'h14_18_04_1E_01_17_3B_3B, 64'h14_18_05_01_02_00_00_00},
    {1'b1, 64'h14_18_01_1F_06_17_3B_3B, 64'h14_18_02_01_07_00_00_00},
    {1'b0, 64'h14_18_05_0A_03_0B_3B_3B, 64'h14_18_05_0A_03_8C_00_00},
    {1'b0, 64'h14_18_05_0A_03_8C_3B_3B, 64'h14_18_05_0A_03_81_00_00},
    {1'b0, 64'h14_18_05_05_03_8B_3B_3B, 64'h14_18_05_06_04_0C_00_00},
    {1'b1, 64'h63_63_0C_1F_07_17_3B_3B, 64'h00_00_01_01_01_00_00_00}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R6", "R5", "R5", "R5", "R5", "R5",
                                  "R4", "R4", "R4", "R6"};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input logic [63:0] t);
    wr(7'h00, t[7:0]);   wr(7'h02, t[15:8]);  wr(7'h04, t[23:16]);
    wr(7'h06, t[31:24]); wr(7'h07, t[39:32]); wr(7'h08, t[47:40]);
    wr(7'h09, t[55:48]); wr(7'h48, t[63:56]);
  endtask

  task automatic get_time(output logic [63:0] t);
    logic [7:0] b;
    rd(7'h00, b); t[7:0]   = b;
    rd(7'h02, b); t[15:8]  = b;
    rd(7'h04, b); t[23:16] = b;
    rd(7'h06, b); t[31:24] = b;
    rd(7'h07, b); t[39:32] = b;
    rd(7'h08, b); t[47:40] = b;
    rd(7'h09, b); t[55:48] = b;
    rd(7'h48, b); t[63:56] = b;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] t;
    logic [7:0]  b;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    get_time(t);
    check("R1 time", t, 64'h00_00_01_01_01_00_00_00);
    rd(7'h0B, b); check("R1 ctrl", {56'd0, b}, 64'h06);
    rd(7'h01, b); check("R1 sec alarm", {56'd0, b}, 64'h00);
    rd(7'h49, b); check("R1 date alarm", {56'd0, b}, 64'h00);
    rd(7'h0C, b); check("R1 flags", {56'd0, b}, 64'h00);
    check("R1 irq", {63'd0, irq}, 64'd0);

    // vector table: one tick across each boundary
    for (int i = 0; i < NV; i++) begin
      wr(7'h0B, VEC[i][128] ? 8'h06 : 8'h04);
      set_time(VEC[i][127:64]);
      tick1();
      get_time(t);
      check(VTAG[i], t, VEC[i][63:0]);
    end

    // R3 24-hour 23 -> 0 carries into the day
    wr(7'h0B, 8'h06);
    set_time(64'h14_18_05_0A_03_17_3B_3B);
    tick1();
    get_time(t);
    check("R3 hour wrap", t, 64'h14_18_05_0B_04_00_00_00);

    // R12 write masking
    wr(7'h00, 8'hFF); rd(7'h00, b); check("R12 sec mask", {56'd0, b}, 64'h3F);
    wr(7'h02, 8'hC5); rd(7'h02, b); check("R12 min full", {56'd0, b}, 64'hC5);

    // R13 unmapped address, century address
    rd(7'h20, b); check("R13 unmapped", {56'd0, b}, 64'h00);
    wr(7'h48, 8'h15); rd(7'h48, b); check("R13 century", {56'd0, b}, 64'h15);

    // R13 write in a tick cycle overrides only its field
    set_time(64'h14_18_05_0A_03_05_05_3B);
    @(negedge clk);
    wr_en = 1'b1; addr = 7'h00; wr_data = 8'h10; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    get_time(t);
    check("R13 write beats tick", t, 64'h14_18_05_0A_03_05_06_10);

    // R7 halt
    wr(7'h0B, 8'h86);
    rd(7'h0C, b);
    set_time(64'h14_18_05_0A_03_05_06_05);
    tick1();
    get_time(t);
    check("R7 halt time", t, 64'h14_18_05_0A_03_05_06_05);
    rd(7'h0C, b); check("R7 halt flags", {56'd0, b}, 64'h00);

    // R8 update flag, R11 clear on read
    wr(7'h0B, 8'h06);
    tick1();
    check("R10 irq off without enables", {63'd0, irq}, 64'd0);
    rd(7'h0C, b); check("R8 update flag", {56'd0, b}, 64'h10);
    rd(7'h0C, b); check("R11 cleared", {56'd0, b}, 64'h00);

    // R11 read and advance in the same cycle
    @(negedge clk);
    rd_en = 1'b1; addr = 7'h0C; tick = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; tick = 1'b0;
    check("R11 race old value", {56'd0, rd_data}, 64'h00);
    rd(7'h0C, b); check("R11 set wins", {56'd0, b}, 64'h10);

    // R9 alarm match with wildcard day, R10 irq via alarm enable
    wr(7'h0B, 8'h26);
    set_time(64'h14_18_05_06_03_0A_14_1D);
    wr(7'h01, 8'h1E); wr(7'h03, 8'h14); wr(7'h05, 8'h0A); wr(7'h49, 8'hC0);
    rd(7'h0C, b);
    tick1();
    check("R10 irq on alarm", {63'd0, irq}, 64'd1);
    rd(7'h0C, b); check("R9 alarm flags", {56'd0, b}, 64'hB0);
    check("R11 irq dropped", {63'd0, irq}, 64'd0);

    // R9 day alarm mismatch blocks the flag
    wr(7'h49, 8'h05);
    set_time(64'h14_18_05_06_03_0A_14_1D);
    tick1();
    check("R9 no irq on mismatch", {63'd0, irq}, 64'd0);
    rd(7'h0C, b); check("R9 mismatch flags", {56'd0, b}, 64'h10);

    // R10 irq via update enable
    wr(7'h0B, 8'h16);
    tick1();
    check("R10 irq on update", {63'd0, irq}, 64'd1);
    rd(7'h0C, b); check("R10 update irq flags", {56'd0, b}, 64'h90);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule